// File: doc/BRIEF.md
# Serial Baud Clock Generator

This block produces the shift clock for one clock-synchronous serial channel. An 8-bit up-counter advances on every cycle in which the count-clock enable is high. It is compared against a programmable match value N. When the counter equals N, the next enabled cycle returns the counter to zero and inverts an internal timer clock. Each half period of that clock is therefore N+1 count ticks long, and the timer clock has an even duty cycle.

A prescaler stage follows the timer clock. It can pass the timer clock straight through, or divide it by 8 or by 16 with an even duty cycle. A channel can be built without the prescaler, and its output is then always the timer clock. In master operation the resulting transfer clock drives the serial clock pin and the pin driver is enabled. In slave operation the pin is left undriven. Clearing the run bit returns every stage to zero.

Top module: `serial_baud_gen`

## Requirements
- R1: While `runEn` is 0, the counter, the timer clock, the prescaler and `xferClk` are all held at 0. After `runEn` is set with `cntTick` high every cycle and pass-through selected, `xferClk` first reads 1 after exactly N+1 clock edges.
- R2: An enabled tick with the counter equal to `matchVal` returns the counter to 0. Any other enabled tick increments the counter by one. With N=0 the counter therefore stays at 0, and the timer clock toggles on every tick.
- R3: The timer clock period is 2×(N+1) count ticks, and its high phase is N+1 ticks.
- R4: A cycle with `cntTick` low changes no state, so `xferClk` holds its level for as long as ticks are absent.
- R5: With `clkMode`=0, `xferClk` follows the timer clock: period 2×(N+1) ticks, high for N+1.
- R6: With `clkMode`=1 and `divSel`=0, `xferClk` has period 16×(N+1) ticks and is high for 8×(N+1). After enabling, it first reads 1 after 7×(N+1) edges.
- R7: With `clkMode`=1 and `divSel`=1, `xferClk` has period 32×(N+1) ticks and is high for 16×(N+1). After enabling, it first reads 1 after 15×(N+1) edges.
- R8: A channel built with `HAS_PRESCALER`=0 produces the timer clock on `xferClk` whatever `clkMode` and `divSel` are set to.
- R9: With `isMaster`=1, `sclkOe` is 1 and `sclkOut` equals `xferClk`. With `isMaster`=0, both are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cntTick | input | 1 | Count-clock enable; one tick per high cycle |
| runEn | input | 1 | Run bit; 0 clears and holds all stages |
| matchVal | input | 8 | Match value N |
| clkMode | input | 1 | 0 selects pass-through, 1 selects prescaler |
| divSel | input | 1 | With prescaler: 0 selects divide by 8, 1 selects divide by 16 |
| isMaster | input | 1 | 1 drives the transfer clock onto the pin |
| xferClk | output | 1 | Transfer clock |
| sclkOut | output | 1 | Serial clock pin data |
| sclkOe | output | 1 | Serial clock pin output enable |

## Verification
The assertions assume that `matchVal`, `clkMode` and `divSel` are static while `runEn` is high. Under that assumption the counter never passes N and every toggle marks a complete half period. The stimulus follows it: each vector first drops `runEn`, then changes the configuration, and only then enables the block again. The tick pattern is started in phase with enabling, so that the first-rise latencies counted in edges hold exactly.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  typedef struct packed {
    logic hold;
    logic step;
    logic wrap;
  } baudStrobe_t;

  typedef enum logic [1:0] {
    DIV_NONE = 2'd0,
    DIV_LO   = 2'd1,
    DIV_HI   = 2'd2
  } divChoice_t;
endpackage

// File: rtl/baud_gen_ctrl.sv
module baud_gen_ctrl
  import baud_gen_pkg::*;
#(
  parameter bit HAS_PRESCALER = 1'b1
) (
  input  logic        runEn,
  input  logic        cntTick,
  input  logic        atMatch,
  input  logic        clkMode,
  input  logic        divSel,
  output baudStrobe_t strobe,
  output divChoice_t  divChoice
);
  always_comb begin
    strobe.hold = !runEn;
    strobe.step = runEn && cntTick;
    strobe.wrap = runEn && cntTick && atMatch;
  end

  generate
    if (HAS_PRESCALER) begin : g_pre
      always_comb begin
        if (!clkMode)    divChoice = DIV_NONE;
        else if (divSel) divChoice = DIV_HI;
        else             divChoice = DIV_LO;
      end
    end else begin : g_nopre
      logic unusedCfg;
      assign unusedCfg = clkMode ^ divSel;
      assign divChoice = DIV_NONE;
    end
  endgenerate
endmodule

// File: rtl/baud_gen_dp.sv
module baud_gen_dp
  import baud_gen_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DIV_A  = 8,
  parameter int DIV_B  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  baudStrobe_t      strobe,
  input  logic [CNT_W-1:0] matchVal,
  input  divChoice_t       divChoice,
  output logic             atMatch,
  output logic             xferClk
);
  localparam int PRE_W = $clog2(DIV_B);
  localparam int BIT_A = $clog2(DIV_A) - 1;
  localparam int BIT_B = $clog2(DIV_B) - 1;

  logic [CNT_W-1:0] cnt;
  logic             tmrClk;
  logic [PRE_W-1:0] pre;
  logic             tmrRise;

  assign atMatch = (cnt == matchVal);
  assign tmrRise = strobe.wrap && !tmrClk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      tmrClk <= 1'b0;
    end else if (strobe.hold) begin
      cnt    <= '0;
      tmrClk <= 1'b0;
    end else if (strobe.wrap) begin
      cnt    <= '0;
      tmrClk <= !tmrClk;
    end else if (strobe.step) begin
      cnt    <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pre <= '0;
    else if (strobe.hold)   pre <= '0;
    else if (tmrRise)       pre <= pre + 1'b1;
  end

  always_comb begin
    unique case (divChoice)
      DIV_LO:  xferClk = pre[BIT_A];
      DIV_HI:  xferClk = pre[BIT_B];
      default: xferClk = tmrClk;
    endcase
  end

  a_r1_held_low: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hold |=> (cnt == '0) && !tmrClk && (pre == '0) && !xferClk);

  a_r2_clear_after_match: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrap |=> (cnt == '0));

  a_r2_count_up: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.wrap) |=> (cnt == $past(cnt) + 1'b1));

  a_r3_toggle_on_wrap: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrap |=> (tmrClk != $past(tmrClk)));

  a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.step && !strobe.hold) |=> ($stable(cnt) && $stable(tmrClk) && $stable(pre)));
endmodule

// File: rtl/serial_baud_gen.sv
module serial_baud_gen
  import baud_gen_pkg::*;
#(
  parameter bit HAS_PRESCALER = 1'b1,
  parameter int CNT_W         = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntTick,
  input  logic             runEn,
  input  logic [CNT_W-1:0] matchVal,
  input  logic             clkMode,
  input  logic             divSel,
  input  logic             isMaster,
  output logic             xferClk,
  output logic             sclkOut,
  output logic             sclkOe
);
  baudStrobe_t strobe;
  divChoice_t  divChoice;
  logic        atMatch;

  baud_gen_ctrl #(.HAS_PRESCALER(HAS_PRESCALER)) u_ctrl (
    .runEn(runEn), .cntTick(cntTick), .atMatch(atMatch),
    .clkMode(clkMode), .divSel(divSel),
    .strobe(strobe), .divChoice(divChoice)
  );

  baud_gen_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .matchVal(matchVal),
    .divChoice(divChoice), .atMatch(atMatch), .xferClk(xferClk)
  );

  assign sclkOe  = isMaster;
  assign sclkOut = isMaster && xferClk;

  a_r9_slave_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !isMaster |-> (!sclkOut && !sclkOe));
endmodule

// File: tb/serial_baud_gen_tb.sv
module serial_baud_gen_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       runEn = 1'b0;
  logic [7:0] matchVal = 8'd0;
  logic       clkMode = 1'b0;
  logic       divSel = 1'b0;
  logic       isMaster = 1'b1;
  logic       xferClk, sclkOut, sclkOe;
  logic       xferNoPre, sclkOutNoPre, sclkOeNoPre;
  logic       cntTick;
  int         tickEvery = 1;
  int         phase = 0;
  int         errors = 0;
  int         checks = 0;

  always #10 clk = !clk;

  assign cntTick = (tickEvery != 0) && (phase == 0);
  always @(posedge clk) begin
    if (!runEn || tickEvery == 0) phase <= 0;
    else phase <= (phase + 1 >= tickEvery) ? 0 : phase + 1;
  end

  serial_baud_gen u_dut (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .runEn(runEn),
    .matchVal(matchVal), .clkMode(clkMode), .divSel(divSel),
    .isMaster(isMaster), .xferClk(xferClk), .sclkOut(sclkOut), .sclkOe(sclkOe)
  );

  serial_baud_gen #(.HAS_PRESCALER(1'b0)) u_dutNoPre (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .runEn(runEn),
    .matchVal(matchVal), .clkMode(clkMode), .divSel(divSel),
    .isMaster(isMaster), .xferClk(xferNoPre), .sclkOut(sclkOutNoPre), .sclkOe(sclkOeNoPre)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input bit sel);
    return sel ? xferNoPre : xferClk;
  endfunction

  // Enables after a clean configuration; returns edges to first high, high and period lengths.
  task automatic runRow(input int n, input bit m, input bit d, input int k, input bit sel,
                        output int first, output int hi, output int per);
    int lo;
    @(negedge clk);
    runEn = 1'b0;
    matchVal = 8'(n); clkMode = m; divSel = d; tickEvery = k;
    repeat (3) @(negedge clk);
    runEn = 1'b1;
    first = 0; hi = 0; lo = 0;
    do begin @(negedge clk); first++; end while (!pick(sel) && first < 20000);
    while (pick(sel) && hi < 20000) begin @(negedge clk); hi++; end
    while (!pick(sel) && lo < 20000) begin @(negedge clk); lo++; end
    per = hi + lo;
  endtask

  typedef struct packed {
    logic [7:0]  n;
    logic        m;
    logic        d;
    logic [3:0]  k;
    logic [15:0] expPer;
    logic [15:0] expFirst;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'd0,   1'b0, 1'b0, 4'd1, 16'd2,   16'd1},    // R2 R5 N=0
    '{8'd1,   1'b0, 1'b0, 4'd1, 16'd4,   16'd2},    // R3 R5
    '{8'd4,   1'b0, 1'b0, 4'd1, 16'd10,  16'd5},    // R3 R5
    '{8'd2,   1'b0, 1'b0, 4'd3, 16'd18,  16'd0},    // R4 sparse ticks
    '{8'd255, 1'b0, 1'b0, 4'd1, 16'd512, 16'd256},  // R3 top match
    '{8'd0,   1'b1, 1'b0, 4'd1, 16'd16,  16'd7},    // R6
    '{8'd1,   1'b1, 1'b0, 4'd1, 16'd32,  16'd14},   // R6
    '{8'd3,   1'b1, 1'b0, 4'd1, 16'd64,  16'd28},   // R6
    '{8'd0,   1'b1, 1'b1, 4'd1, 16'd32,  16'd15},   // R7
    '{8'd2,   1'b1, 1'b1, 4'd2, 16'd192, 16'd0}     // R7 sparse ticks
  };

  initial begin
    fork
      begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none

    // Reset state (R1, R9)
    repeat (3) @(negedge clk);
    check("R1 reset xferClk", xferClk, 0);
    check("R9 master oe at reset", sclkOe, 1);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 disabled xferClk", xferClk, 0);
    check("R9 master pin low", sclkOut, 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      int first, hi, per, mult;
      runRow(VECS[i].n, VECS[i].m, VECS[i].d, VECS[i].k, 1'b0, first, hi, per);
      check($sformatf("R3/R5/R6/R7 period row%0d", i), per, VECS[i].expPer);
      check($sformatf("R3/R5/R6/R7 high row%0d", i), hi, VECS[i].expPer / 2);
      if (VECS[i].k == 1)
        check($sformatf("R1 first rise row%0d", i), first, VECS[i].expFirst);
      // R8: channel without prescaler ignores mode bits
      mult = VECS[i].k;
      runRow(VECS[i].n, VECS[i].m, VECS[i].d, VECS[i].k, 1'b1, first, hi, per);
      check($sformatf("R8 no-prescaler period row%0d", i), per, 2 * (VECS[i].n + 1) * mult);
    end

    // R4: with ticks stopped, output holds its level
    begin
      int first, hi, per;
      runRow(5, 1'b0, 1'b0, 1, 1'b0, first, hi, per);
      @(negedge clk);
      while (!xferClk) @(negedge clk);
      tickEvery = 0;
      repeat (40) @(negedge clk);
      check("R4 held high without ticks", xferClk, 1);
      tickEvery = 1;
    end

    // R1: disabling clears prescaled output at once
    begin
      int first, hi, per;
      runRow(0, 1'b1, 1'b1, 1, 1'b0, first, hi, per);
      while (!xferClk) @(negedge clk);
      runEn = 1'b0;
      @(negedge clk);
      check("R1 clear on disable", xferClk, 0);
      repeat (20) @(negedge clk);
      check("R1 stays low while disabled", xferClk, 0);
    end

    // R9: master and slave pin behaviour
    begin
      int first, hi, per;
      isMaster = 1'b1;
      runRow(1, 1'b0, 1'b0, 1, 1'b0, first, hi, per);
      while (!xferClk) @(negedge clk);
      check("R9 master pin follows", sclkOut, 1);
      check("R9 master oe", sclkOe, 1);
      isMaster = 1'b0;
      @(negedge clk);
      while (!xferClk) @(negedge clk);
      check("R9 slave pin quiet", sclkOut, 0);
      check("R9 slave oe off", sclkOe, 0);
      check("R9 clock runs in slave", xferClk, 1);
      isMaster = 1'b1;
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule